// File: doc/BRIEF.md
# Interleaved I/Q Word Formatter for a Dual Converter

This block takes a single 12-bit bus that carries words for two converter channels, I and Q, one word per input clock, and turns it into two parallel channel codes that update together at half the input clock rate. Each word arrives with two side bits: a channel-steering bit and an invert bit. The block registers the word and its side bits on the rising clock edge, optionally complements every data bit, and converts the result from the selected input coding into an unsigned converter code. It then places the word into the I or Q holding slot.

Once per pair of input clocks, the two holding slots are copied out together through a fixed delay. An I word and the Q word sampled one clock later therefore reach the outputs on the same update, and a one-cycle strobe marks that update. A power-down input clears the pipeline: while it is sampled high, both codes sit at midscale and the strobe stays low. After power-down is released, no strobe appears until the first real pair has passed through the whole pipeline.

Top module: `iq_dac_formatter`

## Requirements
- R1: After a clock edge with `rst` high, both `i_code` and `q_code` equal midscale (0x800, only bit 11 set) and `pair_vld` is low.
- R2: A word sampled with `bus_to_i` high is written to the I channel. A word sampled with `bus_to_i` low is written to the Q channel.
- R3: With `bus_invert` high, all 12 data bits of that word are complemented before format conversion. With `bus_invert` low, the bits pass as they are.
- R4: With `twos_fmt` low, the (possibly inverted) word is taken as offset binary and is output unchanged. With `twos_fmt` high, it is taken as two's complement and is offset by half scale: 0x800 gives 0x000, 0x000 gives 0x800, and 0x7FF gives 0xFFF.
- R5: The first word sampled after reset or power-down release is an I slot, and the slots then alternate. An I word sampled at edge k and the Q word sampled at edge k+1 appear together on `i_code`/`q_code` just after edge k+9. This is 9 clocks of latency on I and 8 on Q.
- R6: `pair_vld` is high for exactly one clock in every two while data flows. The codes stay unchanged for the clock that follows each strobe.
- R7: After a clock edge with `pwr_down` high, both codes equal midscale and `pair_vld` is low.
- R8: After power-down or reset is released, `pair_vld` stays low until 10 edges after the last clearing edge, when the first complete pair is shown.
- R9: If two consecutive words carry the same steering value, the later word replaces that channel's pending sample. The other channel repeats its previous value in the next pair.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input word clock, twice the channel update rate |
| rst | input | 1 | Synchronous active-high reset |
| bus_data | input | 12 | Interleaved data word |
| bus_to_i | input | 1 | Per-word steering: 1 = I channel, 0 = Q channel |
| bus_invert | input | 1 | Per-word invert: 1 = complement all data bits |
| twos_fmt | input | 1 | Input coding: 1 = two's complement, 0 = offset binary |
| pwr_down | input | 1 | Active-high power-down; tie low for normal operation |
| i_code | output | 12 | Unsigned I channel code |
| q_code | output | 12 | Unsigned Q channel code |
| pair_vld | output | 1 | One-clock strobe marking a new I/Q pair |

## Verification
The first pattern is a strictly alternating I/Q stream with pseudo-random data. It shows whether steering and the unequal I/Q latencies line up, because a one-clock error on either channel splits a pair. A second stream toggles the invert bit word by word and switches the coding to two's complement with the boundary words 0x800, 0x000 and 0x7FF. This separates inversion order and the half-scale offset from plain pass-through. Streams that repeat the steering value check the overwrite rule and that the idle channel keeps its value. Power-down and reset in the middle of a stream, followed by restart, check the midscale clear, the flush delay and the restart of slot parity.

// File: rtl/iqdf_pkg.sv
`timescale 1ns/1ps
package iqdf_pkg;

    // Slot marker: which half of an input pair the current edge belongs to.
    typedef enum logic {
        SLOT_I = 1'b0,
        SLOT_Q = 1'b1
    } slot_e;

    // Side information that travels with every bus word.
    typedef struct packed {
        logic to_i;    // steer word to I (1) or Q (0)
        logic invert;  // complement all data bits
        logic twos;    // word is two's complement coded
    } word_ctl_t;

    // Edges after a clear before the holding slots contain a complete pair:
    // capture, format, I slot write, Q slot write.
    localparam int unsigned PAIR_READY_EDGES = 4;

    // Two's complement to unsigned code differs only in the sign bit.
    function automatic logic sign_to_offset(input logic twos, input logic msb);
        return msb ^ twos;
    endfunction

endpackage

// File: rtl/iqdf_capture.sv
`timescale 1ns/1ps
module iqdf_capture
    import iqdf_pkg::*;
#(
    parameter int DW = 12
) (
    input  logic            clk,
    input  logic            clr,
    input  logic [DW-1:0]   din,
    input  word_ctl_t       ctl_in,
    output logic            word_vld,
    output logic            word_to_i,
    output logic [DW-1:0]   word_code
);

    logic [DW-1:0] raw_q;
    word_ctl_t     ctl_q;
    logic          raw_vld;
    logic [DW-1:0] code_d;

    // Stage 1: sample word and side bits on the rising edge.
    always_ff @(posedge clk) begin
        if (clr) begin
            raw_q   <= '0;
            ctl_q   <= '0;
            raw_vld <= 1'b0;
        end else begin
            raw_q   <= din;
            ctl_q   <= ctl_in;
            raw_vld <= 1'b1;
        end
    end

    // Inversion first, then coding conversion.
    always_comb begin
        code_d         = raw_q ^ {DW{ctl_q.invert}};
        code_d[DW-1]   = sign_to_offset(ctl_q.twos, code_d[DW-1]);
    end

    // Stage 2: formatted word with its steering bit.
    always_ff @(posedge clk) begin
        if (clr) begin
            word_vld  <= 1'b0;
            word_to_i <= 1'b0;
            word_code <= '0;
        end else begin
            word_vld  <= raw_vld;
            word_to_i <= ctl_q.to_i;
            word_code <= code_d;
        end
    end

endmodule

// File: rtl/iqdf_steer.sv
`timescale 1ns/1ps
module iqdf_steer
    import iqdf_pkg::*;
#(
    parameter int DW = 12
) (
    input  logic            clk,
    input  logic            clr,
    input  logic            word_vld,
    input  logic            word_to_i,
    input  logic [DW-1:0]   word_code,
    output logic            pair_vld,
    output logic [DW-1:0]   pair_i,
    output logic [DW-1:0]   pair_q
);

    localparam int FW = $clog2(PAIR_READY_EDGES + 1);
    localparam logic [FW-1:0] FILL_DONE = FW'(PAIR_READY_EDGES);
    localparam logic [DW-1:0] MID = {1'b1, {(DW-1){1'b0}}};

    slot_e         phase;
    logic [FW-1:0] fill;
    logic [DW-1:0] hold_i;
    logic [DW-1:0] hold_q;
    logic          ready;

    assign ready = (phase == SLOT_I) && (fill == FILL_DONE);

    // Slot phase and fill counter restart on every clear.
    always_ff @(posedge clk) begin
        if (clr) begin
            phase <= SLOT_I;
            fill  <= '0;
        end else begin
            phase <= (phase == SLOT_I) ? SLOT_Q : SLOT_I;
            if (fill != FILL_DONE) begin
                fill <= fill + 1'b1;
            end
        end
    end

    // Per-channel holding slots; a repeated steering value overwrites.
    always_ff @(posedge clk) begin
        if (clr) begin
            hold_i <= MID;
            hold_q <= MID;
        end else if (word_vld) begin
            if (word_to_i) begin
                hold_i <= word_code;
            end else begin
                hold_q <= word_code;
            end
        end
    end

    // Pair register, loaded once per two input clocks.
    always_ff @(posedge clk) begin
        if (clr) begin
            pair_vld <= 1'b0;
            pair_i   <= MID;
            pair_q   <= MID;
        end else begin
            pair_vld <= ready;
            if (ready) begin
                pair_i <= hold_i;
                pair_q <= hold_q;
            end
        end
    end

endmodule

// File: rtl/iqdf_align.sv
`timescale 1ns/1ps
module iqdf_align #(
    parameter int DW    = 12,
    parameter int DEPTH = 5
) (
    input  logic            clk,
    input  logic            clr,
    input  logic            in_vld,
    input  logic [DW-1:0]   in_i,
    input  logic [DW-1:0]   in_q,
    output logic            out_vld,
    output logic [DW-1:0]   out_i,
    output logic [DW-1:0]   out_q
);

    localparam logic [DW-1:0] MID = {1'b1, {(DW-1){1'b0}}};

    typedef struct packed {
        logic          vld;
        logic [DW-1:0] i;
        logic [DW-1:0] q;
    } tap_t;

    tap_t head;
    tap_t stage_q [DEPTH];

    assign head = '{vld: in_vld, i: in_i, q: in_q};

    for (genvar g = 0; g < DEPTH; g++) begin : g_tap
        tap_t src;
        if (g == 0) begin : g_first
            assign src = head;
        end else begin : g_next
            assign src = stage_q[g-1];
        end
        always_ff @(posedge clk) begin
            if (clr) begin
                stage_q[g] <= '{vld: 1'b0, i: MID, q: MID};
            end else begin
                stage_q[g] <= src;
            end
        end
    end

    assign out_vld = stage_q[DEPTH-1].vld;
    assign out_i   = stage_q[DEPTH-1].i;
    assign out_q   = stage_q[DEPTH-1].q;

endmodule

// File: rtl/iq_dac_formatter.sv
`timescale 1ns/1ps
module iq_dac_formatter
    import iqdf_pkg::*;
#(
    parameter int DW        = 12,
    parameter int I_LATENCY = 9
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [DW-1:0]   bus_data,
    input  logic            bus_to_i,
    input  logic            bus_invert,
    input  logic            twos_fmt,
    input  logic            pwr_down,
    output logic [DW-1:0]   i_code,
    output logic [DW-1:0]   q_code,
    output logic            pair_vld
);

    // Pair register lands PAIR_READY_EDGES after the I sample; the rest
    // of the I latency is a plain delay line.
    localparam int ALIGN_DEPTH = I_LATENCY - PAIR_READY_EDGES;

    logic          clr;
    word_ctl_t     ctl_in;
    logic          word_vld;
    logic          word_to_i;
    logic [DW-1:0] word_code;
    logic          pr_vld;
    logic [DW-1:0] pr_i;
    logic [DW-1:0] pr_q;

    assign clr    = rst | pwr_down;
    assign ctl_in = '{to_i: bus_to_i, invert: bus_invert, twos: twos_fmt};

    iqdf_capture #(.DW(DW)) u_capture (
        .clk       (clk),
        .clr       (clr),
        .din       (bus_data),
        .ctl_in    (ctl_in),
        .word_vld  (word_vld),
        .word_to_i (word_to_i),
        .word_code (word_code)
    );

    iqdf_steer #(.DW(DW)) u_steer (
        .clk       (clk),
        .clr       (clr),
        .word_vld  (word_vld),
        .word_to_i (word_to_i),
        .word_code (word_code),
        .pair_vld  (pr_vld),
        .pair_i    (pr_i),
        .pair_q    (pr_q)
    );

    iqdf_align #(.DW(DW), .DEPTH(ALIGN_DEPTH)) u_align (
        .clk     (clk),
        .clr     (clr),
        .in_vld  (pr_vld),
        .in_i    (pr_i),
        .in_q    (pr_q),
        .out_vld (pair_vld),
        .out_i   (i_code),
        .out_q   (q_code)
    );

endmodule

// File: rtl/iq_dac_formatter_chk.sv
`timescale 1ns/1ps
module iq_dac_formatter_chk #(
    parameter int DW        = 12,
    parameter int I_LATENCY = 9
) (
    input logic            clk,
    input logic            rst,
    input logic            pwr_down,
    input logic            pair_vld,
    input logic [DW-1:0]   i_code,
    input logic [DW-1:0]   q_code
);

    localparam logic [DW-1:0] MID = {1'b1, {(DW-1){1'b0}}};
    localparam int LIM = I_LATENCY + 1;
    localparam int CW  = $clog2(LIM + 1);

    logic [CW-1:0] since_clr;

    always_ff @(posedge clk) begin
        if (rst || pwr_down) begin
            since_clr <= '0;
        end else if (since_clr != CW'(LIM)) begin
            since_clr <= since_clr + 1'b1;
        end
    end

    // R1
    a_r1_reset_quiet: assert property (@(posedge clk)
        $past(rst) |-> (!pair_vld && i_code == MID && q_code == MID));

    // R7
    a_r7_pd_midscale: assert property (@(posedge clk) disable iff (rst)
        $past(pwr_down) |-> (!pair_vld && i_code == MID && q_code == MID));

    // R6
    a_r6_single_strobe: assert property (@(posedge clk) disable iff (rst)
        pair_vld |=> !pair_vld);

    // R6
    a_r6_codes_held: assert property (@(posedge clk) disable iff (rst)
        pair_vld |=> (($stable(i_code) && $stable(q_code)) || $past(pwr_down) || $past(rst)));

    // R8
    a_r8_flush_gap: assert property (@(posedge clk) disable iff (rst || pwr_down)
        pair_vld |-> (since_clr >= CW'(LIM)));

endmodule

bind iq_dac_formatter iq_dac_formatter_chk #(.DW(DW), .I_LATENCY(I_LATENCY)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .pwr_down (pwr_down),
    .pair_vld (pair_vld),
    .i_code   (i_code),
    .q_code   (q_code)
);

// File: tb/iq_dac_formatter_bench.sv
`timescale 1ns/1ps
module iq_dac_formatter_bench;

    localparam int  MIDV     = 2048;
    localparam int  LAG      = 8;
    localparam int  WD_LIMIT = 200000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] bus_data = '0;
    logic        bus_to_i = 1'b0;
    logic        bus_invert = 1'b0;
    logic        twos_fmt = 1'b0;
    logic        pwr_down = 1'b0;
    logic [11:0] i_code;
    logic [11:0] q_code;
    logic        pair_vld;

    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    string tag = "R1";

    always #2.5 clk = ~clk;

    iq_dac_formatter u_iq_dac_formatter (
        .clk        (clk),
        .rst        (rst),
        .bus_data   (bus_data),
        .bus_to_i   (bus_to_i),
        .bus_invert (bus_invert),
        .twos_fmt   (twos_fmt),
        .pwr_down   (pwr_down),
        .i_code     (i_code),
        .q_code     (q_code),
        .pair_vld   (pair_vld)
    );

    // Behavioural reference: channel state plus a queue of per-edge results.
    int q_v[$];
    int q_i[$];
    int q_q[$];
    int st_i = MIDV, st_q = MIDV, last_i = MIDV, last_q = MIDV;
    int slot = 0;
    int w;
    int exp_i = MIDV, exp_q = MIDV, exp_v = 0;

    always @(posedge clk) begin
        if (rst || pwr_down) begin
            q_v.delete(); q_i.delete(); q_q.delete();
            for (int n = 0; n < LAG; n++) begin
                q_v.push_back(0); q_i.push_back(MIDV); q_q.push_back(MIDV);
            end
            st_i = MIDV; st_q = MIDV; last_i = MIDV; last_q = MIDV;
            slot = 0;
            exp_i = MIDV; exp_q = MIDV; exp_v = 0;
        end else begin
            w = int'(bus_data);
            if (bus_invert) w = 4095 - w;
            if (twos_fmt) w = (w + 2048) % 4096;
            if (bus_to_i) st_i = w; else st_q = w;
            if (slot % 2 == 1) begin
                last_i = st_i; last_q = st_q;
                q_v.push_back(1);
            end else begin
                q_v.push_back(0);
            end
            q_i.push_back(last_i); q_q.push_back(last_q);
            exp_v = q_v.pop_front();
            exp_i = q_i.pop_front();
            exp_q = q_q.pop_front();
            slot++;
        end
    end

    // Compare on every clock, away from the active edge.
    always @(negedge clk) begin
        if (!done) begin
            checks++;
            if (int'(i_code) != exp_i || int'(q_code) != exp_q || int'(pair_vld) != exp_v) begin
                errors++;
                $display("FAIL %s: i=%h q=%h v=%0d expected i=%h q=%h v=%0d",
                         tag, i_code, q_code, pair_vld, exp_i[11:0], exp_q[11:0], exp_v);
            end
        end
    end

    task automatic put(input logic s, input logic inv, input logic tc, input logic [11:0] d);
        @(negedge clk);
        bus_to_i   = s;
        bus_invert = inv;
        twos_fmt   = tc;
        bus_data   = d;
    endtask

    logic [31:0] seed = 32'h1234_5678;
    function automatic logic [11:0] next_rand();
        seed = seed * 32'd1103515245 + 32'd12345;
        return seed[27:16];
    endfunction

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        #(WD_LIMIT * 5);
        checks++;
        errors++;
        $display("FAIL watchdog: actual still running, expected finished");
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        int vcount;
        // R1: reset state
        tag = "R1";
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R5: first pair after reset, latency alignment
        tag = "R5";
        put(1'b1, 1'b0, 1'b0, 12'h123);
        put(1'b0, 1'b0, 1'b0, 12'h456);
        for (int n = 0; n < 6; n++) put(n % 2 == 0, 1'b0, 1'b0, 12'(n * 17));

        // R2: alternating steering with varied data
        tag = "R2";
        for (int n = 0; n < 40; n++) put(n % 2 == 0, 1'b0, 1'b0, next_rand());

        // R3: per-word inversion
        tag = "R3";
        for (int n = 0; n < 24; n++) put(n % 2 == 0, (n % 3) == 1, 1'b0, next_rand());

        // R4: two's complement boundaries, then offset binary again
        tag = "R4";
        put(1'b1, 1'b0, 1'b1, 12'h800);
        put(1'b0, 1'b0, 1'b1, 12'h000);
        put(1'b1, 1'b0, 1'b1, 12'h7FF);
        put(1'b0, 1'b1, 1'b1, 12'h7FF);
        put(1'b1, 1'b0, 1'b0, 12'hFFF);
        put(1'b0, 1'b0, 1'b0, 12'h000);
        for (int n = 0; n < 12; n++) put(n % 2 == 0, 1'b0, 1'b1, next_rand());

        // R9: repeated steering values overwrite one channel
        tag = "R9";
        put(1'b1, 1'b0, 1'b0, 12'hAAA);
        put(1'b1, 1'b0, 1'b0, 12'h555);
        put(1'b0, 1'b0, 1'b0, 12'h0F0);
        put(1'b0, 1'b0, 1'b0, 12'h0E1);
        put(1'b0, 1'b0, 1'b0, 12'h3C3);
        put(1'b0, 1'b0, 1'b0, 12'h111);
        for (int n = 0; n < 12; n++) put(n % 2 == 0, 1'b0, 1'b0, next_rand());

        // R7: power-down mid-stream
        tag = "R7";
        @(negedge clk);
        pwr_down = 1'b1;
        for (int n = 0; n < 8; n++) put(n % 2 == 0, 1'b0, 1'b0, next_rand());

        // R8: release and flush
        tag = "R8";
        @(negedge clk);
        pwr_down = 1'b0;
        bus_to_i = 1'b1;
        bus_data = 12'h9AB;
        put(1'b0, 1'b0, 1'b0, 12'h0CD);
        for (int n = 0; n < 20; n++) put(n % 2 == 0, 1'b0, 1'b0, next_rand());

        // R6: exactly one strobe per two clocks
        tag = "R6";
        vcount = 0;
        for (int n = 0; n < 40; n++) begin
            put(n % 2 == 0, 1'b0, 1'b0, next_rand());
            vcount += int'(pair_vld);
        end
        checks++;
        if (vcount != 20) begin
            errors++;
            $display("FAIL R6: strobe count %0d expected %0d", vcount, 20);
        end

        // R1: reset in the middle of traffic
        tag = "R1";
        @(negedge clk);
        rst = 1'b1;
        for (int n = 0; n < 3; n++) put(n % 2 == 0, 1'b0, 1'b0, next_rand());
        @(negedge clk);
        rst = 1'b0;
        tag = "R5";
        for (int n = 0; n < 24; n++) put(n % 2 == 0, 1'b0, 1'b0, next_rand());
        repeat (2) @(negedge clk);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule